// File: doc/BRIEF.md
# PoE Powered-Device Power Sequencer

This block is the digital sequencer in the front end of a Power-over-Ethernet powered device. It reads single-bit comparator decisions about the port voltage, the pass transistor's drain-source and gate-source voltages, die over-temperature and an auxiliary-supply request. From these it drives five controls: the detection-resistor pulldown, the classification current source, the pass-switch enable, the current-limit select, and the open-drain power-good output.

Every comparator bit first passes through a two-flop synchronizer. Each timing qualification is a saturating cycle counter that clears as soon as its condition drops. The sequencer has four states. In `ST_DETECT` the detection pin is pulled low. `ST_CLASSIFY` is entered when the classification-window comparator first asserts. `ST_INRUSH` is entered when the turn-on qualifier expires, and there the switch conducts at the low inrush limit. `ST_POWER` is entered when the power-good qualifier expires, and there the operational limit is used and power-good is released.

The named transitions are:
- DETECT→CLASSIFY: the window comparator asserts.
- CLASSIFY→DETECT: the input stays below the turn-off level and outside the window for the voltage filter time.
- CLASSIFY→INRUSH: the input stays above the turn-on level for the voltage filter time.
- INRUSH→POWER: drain-source below 1 V and gate-source above 2 V both hold for the power-good filter time.
- POWER→INRUSH: drain-source stays above 10 V for the power-good filter time, with no auxiliary request; or over-temperature occurs.
- INRUSH/POWER→DETECT: the input stays below the turn-off level for the voltage filter time.

Top module: `poe_pd_seq`

## Requirements
- R1: While reset is asserted and just after it, det_pull_en=1, class_src_en=0, pass_sw_en=0, ilim_oper_sel=0 (0 selects inrush limit, 1 operational) and pgood_pull_low=1 (1 pulls the pin low, 0 leaves it high-impedance, meaning power good).
- R2: In detection, a synchronized vin_in_class high moves the block to classification and det_pull_en goes to 0; it stays 0 in every later state until detection is re-entered.
- R3: class_src_en is 1 only in classification while vin_in_class is high and temp_fault is low.
- R4: In classification, vin_below_off high with vin_in_class low for UV_FILT_CYCLES consecutive cycles returns the block to detection.
- R5: In classification, vin_above_on high for UV_FILT_CYCLES consecutive cycles turns the pass switch on, with ilim_oper_sel=0 and pgood_pull_low=1.
- R6: In inrush, vds_under_1v and vgs_over_2v both high for PG_FILT_CYCLES consecutive cycles set ilim_oper_sel=1 and pgood_pull_low=0; a shorter joint assertion leaves inrush unchanged.
- R7: In power mode, vds_over_10v high for PG_FILT_CYCLES consecutive cycles (with no auxiliary request) returns to ilim_oper_sel=0 and pgood_pull_low=1; a shorter excursion leaves power mode unchanged.
- R8: With the switch on, vin_below_off high for UV_FILT_CYCLES consecutive cycles turns the switch off and re-enters detection; a shorter dip is ignored.
- R9: While synchronized temp_fault is high, class_src_en=0, pass_sw_en=0 and pgood_pull_low=1; when it clears, the sequence resumes without reset.
- R10: While synchronized aux_request is high, pass_sw_en=0; in power mode pgood_pull_low stays 0 and vds_over_10v is not acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_above_on | input | 1 | Port voltage above turn-on level |
| vin_below_off | input | 1 | Port voltage below turn-off level |
| vin_in_class | input | 1 | Port voltage inside classification window |
| vds_under_1v | input | 1 | Pass-switch drain-source below 1 V |
| vds_over_10v | input | 1 | Pass-switch drain-source above 10 V |
| vgs_over_2v | input | 1 | Pass-switch gate-source above 2 V |
| temp_fault | input | 1 | Die over-temperature |
| aux_request | input | 1 | Auxiliary supply takes over |
| det_pull_en | output | 1 | Pull detection pin to ground |
| class_src_en | output | 1 | Enable classification current source |
| pass_sw_en | output | 1 | Enable pass switch |
| ilim_oper_sel | output | 1 | 1 = operational limit, 0 = inrush limit |
| pgood_pull_low | output | 1 | 1 = drive power-good low, 0 = high-impedance |

## Verification
The assertions check the following on every cycle:
- Detection excludes both classification and conduction.
- The classification source is never on outside the window.
- A fault or an auxiliary request forces the switch off.
- Power-good release is always paired with the operational limit and follows the two qualifying drain and gate conditions.
- Power-good is withdrawn only after a drain excursion, a supply drop or a fault.
- The switch always starts at the inrush limit.

Only the bench scenarios can show the timing side:
- Long conditions are acted on and short ones are ignored.
- Operation resumes after over-temperature clears.
- The full walk from detection to power and back behaves as specified.

// File: rtl/poe_pd_pkg.sv
package poe_pd_pkg;

    typedef enum logic [1:0] {
        ST_DETECT   = 2'd0,
        ST_CLASSIFY = 2'd1,
        ST_INRUSH   = 2'd2,
        ST_POWER    = 2'd3
    } pd_state_t;

    // synchronized comparator bit positions
    localparam int IN_AON  = 0;
    localparam int IN_BOFF = 1;
    localparam int IN_WIN  = 2;
    localparam int IN_VDSL = 3;
    localparam int IN_VDSH = 4;
    localparam int IN_VGS  = 5;
    localparam int IN_OT   = 6;
    localparam int IN_AUX  = 7;
    localparam int NUM_IN  = 8;

    // qualifier slots
    localparam int Q_ON   = 0;
    localparam int Q_OFF  = 1;
    localparam int Q_PG   = 2;
    localparam int Q_VDSH = 3;
    localparam int NUM_Q  = 4;

endpackage

// File: rtl/poe_pd_sync.sv
module poe_pd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/poe_pd_qual.sv
module poe_pd_qual #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic done
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] CMAX = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // qualified only while the condition is still present
    assign done = cond && (cnt == CMAX);
endmodule

// File: rtl/poe_pd_seq.sv
module poe_pd_seq
    import poe_pd_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int UV_FILT_CYCLES = 25_000_000,
    parameter int PG_FILT_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin_above_on,
    input  logic vin_below_off,
    input  logic vin_in_class,
    input  logic vds_under_1v,
    input  logic vds_over_10v,
    input  logic vgs_over_2v,
    input  logic temp_fault,
    input  logic aux_request,
    output logic det_pull_en,
    output logic class_src_en,
    output logic pass_sw_en,
    output logic ilim_oper_sel,
    output logic pgood_pull_low
);
    logic [NUM_IN-1:0] raw_in, syn_in;
    logic [NUM_Q-1:0]  q_cond, q_done;
    pd_state_t         state_q, state_d;

    logic aon_s, boff_s, win_s, vdsl_s, vdsh_s, vgs_s, ot_s, aux_s;

    assign raw_in[IN_AON]  = vin_above_on;
    assign raw_in[IN_BOFF] = vin_below_off;
    assign raw_in[IN_WIN]  = vin_in_class;
    assign raw_in[IN_VDSL] = vds_under_1v;
    assign raw_in[IN_VDSH] = vds_over_10v;
    assign raw_in[IN_VGS]  = vgs_over_2v;
    assign raw_in[IN_OT]   = temp_fault;
    assign raw_in[IN_AUX]  = aux_request;

    poe_pd_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (syn_in)
    );

    assign aon_s  = syn_in[IN_AON];
    assign boff_s = syn_in[IN_BOFF];
    assign win_s  = syn_in[IN_WIN];
    assign vdsl_s = syn_in[IN_VDSL];
    assign vdsh_s = syn_in[IN_VDSH];
    assign vgs_s  = syn_in[IN_VGS];
    assign ot_s   = syn_in[IN_OT];
    assign aux_s  = syn_in[IN_AUX];

    logic switch_state;
    assign switch_state = (state_q == ST_INRUSH) || (state_q == ST_POWER);

    // qualifying conditions, gated by state so each counter restarts on entry
    assign q_cond[Q_ON]   = (state_q == ST_CLASSIFY) && aon_s;
    assign q_cond[Q_OFF]  = boff_s && (switch_state ||
                            ((state_q == ST_CLASSIFY) && !win_s));
    assign q_cond[Q_PG]   = (state_q == ST_INRUSH) && vdsl_s && vgs_s && !ot_s;
    assign q_cond[Q_VDSH] = (state_q == ST_POWER) && vdsh_s && !aux_s;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_qual
        localparam int LIM = (g == Q_ON || g == Q_OFF) ? UV_FILT_CYCLES
                                                        : PG_FILT_CYCLES;
        poe_pd_qual #(.LIMIT(LIM)) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .cond (q_cond[g]),
            .done (q_done[g])
        );
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DETECT: begin
                if (win_s) state_d = ST_CLASSIFY;
            end
            ST_CLASSIFY: begin
                if (q_done[Q_OFF])     state_d = ST_DETECT;
                else if (q_done[Q_ON]) state_d = ST_INRUSH;
            end
            ST_INRUSH: begin
                if (q_done[Q_OFF])     state_d = ST_DETECT;
                else if (q_done[Q_PG]) state_d = ST_POWER;
            end
            ST_POWER: begin
                if (q_done[Q_OFF])                 state_d = ST_DETECT;
                else if (ot_s || q_done[Q_VDSH])   state_d = ST_INRUSH;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DETECT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        det_pull_en    = 1'b0;
        class_src_en   = 1'b0;
        pass_sw_en     = 1'b0;
        ilim_oper_sel  = 1'b0;
        pgood_pull_low = 1'b1;
        unique case (state_q)
            ST_DETECT: begin
                det_pull_en = 1'b1;
            end
            ST_CLASSIFY: begin
                class_src_en = win_s && !ot_s;
            end
            ST_INRUSH: begin
                pass_sw_en = !ot_s && !aux_s;
            end
            ST_POWER: begin
                pass_sw_en     = !ot_s && !aux_s;
                ilim_oper_sel  = !ot_s;
                pgood_pull_low = ot_s;
            end
        endcase
    end
endmodule

// File: rtl/poe_pd_seq_chk.sv
module poe_pd_seq_chk
    import poe_pd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input pd_state_t state_q,
    input logic      win_s,
    input logic      vdsl_s,
    input logic      vdsh_s,
    input logic      vgs_s,
    input logic      boff_s,
    input logic      ot_s,
    input logic      aux_s,
    input logic      det_pull_en,
    input logic      class_src_en,
    input logic      pass_sw_en,
    input logic      ilim_oper_sel,
    input logic      pgood_pull_low
);
    p_detect_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        det_pull_en |-> (!pass_sw_en && !class_src_en));

    p_class_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        class_src_en |-> (win_s && !ot_s));

    p_start_inrush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pass_sw_en) && $past(state_q) == ST_CLASSIFY) |-> !ilim_oper_sel);

    p_pg_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgood_pull_low) |-> ($past(vdsl_s) && $past(vgs_s)) || $past(ot_s));

    p_pg_oper_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood_pull_low |-> ilim_oper_sel);

    p_pg_drop_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood_pull_low) |-> (ot_s || $past(vdsh_s) || $past(boff_s)));

    p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ot_s |-> (!pass_sw_en && pgood_pull_low && !class_src_en));

    p_aux_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        aux_s |-> !pass_sw_en);
endmodule

bind poe_pd_seq poe_pd_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_q       (state_q),
    .win_s         (win_s),
    .vdsl_s        (vdsl_s),
    .vdsh_s        (vdsh_s),
    .vgs_s         (vgs_s),
    .boff_s        (boff_s),
    .ot_s          (ot_s),
    .aux_s         (aux_s),
    .det_pull_en   (det_pull_en),
    .class_src_en  (class_src_en),
    .pass_sw_en    (pass_sw_en),
    .ilim_oper_sel (ilim_oper_sel),
    .pgood_pull_low(pgood_pull_low)
);

// File: tb/poe_pd_seq_test.sv
module poe_pd_seq_test;
    localparam int UVF  = 6;
    localparam int PGF  = 8;
    localparam int HOLD = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    // {aux, ot, vgs, vdsh, vdsl, win, boff, aon}
    logic [7:0] stim = 8'b0000_0010;
    logic det, cls, pass, ilim, pgl;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    poe_pd_seq #(
        .SYNC_STAGES(2), .UV_FILT_CYCLES(UVF), .PG_FILT_CYCLES(PGF)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .vin_above_on  (stim[0]),
        .vin_below_off (stim[1]),
        .vin_in_class  (stim[2]),
        .vds_under_1v  (stim[3]),
        .vds_over_10v  (stim[4]),
        .vgs_over_2v   (stim[5]),
        .temp_fault    (stim[6]),
        .aux_request   (stim[7]),
        .det_pull_en   (det),
        .class_src_en  (cls),
        .pass_sw_en    (pass),
        .ilim_oper_sel (ilim),
        .pgood_pull_low(pgl)
    );

    // {stim[7:0], expected {pgl, ilim, pass, cls, det}, requirement number}
    localparam int NV = 15;
    localparam logic [16:0] VEC [NV] = '{
        {8'b0000_0010, 5'b10001, 4'd1},  // R1 idle in detection
        {8'b0000_0110, 5'b10010, 4'd2},  // R2 window -> classify, R3 source on
        {8'b0000_0010, 5'b10001, 4'd4},  // R4 below off, outside window
        {8'b0000_0110, 5'b10010, 4'd3},  // R3 classify again
        {8'b0000_0001, 5'b10100, 4'd5},  // R5 turn-on at inrush limit
        {8'b0000_1001, 5'b10100, 4'd6},  // R6 vds low alone not enough
        {8'b0010_1001, 5'b01100, 4'd6},  // R6 power mode
        {8'b1001_0001, 5'b01000, 4'd10}, // R10 aux: switch off, pg kept
        {8'b0001_0001, 5'b10100, 4'd7},  // R7 long excursion -> inrush
        {8'b0010_1001, 5'b01100, 4'd6},  // R6 power again
        {8'b0110_1001, 5'b10000, 4'd9},  // R9 fault shuts all
        {8'b0010_1001, 5'b01100, 4'd9},  // R9 resumes
        {8'b0000_0010, 5'b10001, 4'd8},  // R8 supply loss -> detection
        {8'b0100_0110, 5'b10000, 4'd9},  // R9 fault blocks class source
        {8'b0000_0110, 5'b10010, 4'd3}   // R3 source back on
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [4:0] exp, input int req);
        logic [4:0] act;
        act = {pgl, ilim, pass, cls, det};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: outputs {pgl,ilim,pass,cls,det} = %b, expected %b",
                     req, act, exp);
        end
    endtask

    initial begin
        wait_cyc(3);
        check(5'b10001, 1);               // R1 during reset
        rst_n = 1'b1;
        wait_cyc(2);
        check(5'b10001, 1);               // R1 after reset

        for (int i = 0; i < NV; i++) begin
            stim = VEC[i][16:9];
            wait_cyc(HOLD);
            check(VEC[i][8:4], int'(VEC[i][3:0]));
        end

        // reach power mode
        stim = 8'b0000_0001; wait_cyc(HOLD);
        stim = 8'b0010_1001; wait_cyc(HOLD);
        check(5'b01100, 6);               // R6

        // R7 short drain excursion ignored
        stim = 8'b0011_0001; wait_cyc(PGF / 2);
        stim = 8'b0010_1001; wait_cyc(12);
        check(5'b01100, 7);

        // R8 short supply dip ignored
        stim = 8'b0010_1010; wait_cyc(UVF / 2);
        stim = 8'b0010_1001; wait_cyc(12);
        check(5'b01100, 8);

        // R7 long excursion back to inrush
        stim = 8'b0001_0001; wait_cyc(HOLD);
        check(5'b10100, 7);

        // R6 brief qualifying pulse does not release power-good
        stim = 8'b0010_1001; wait_cyc(PGF / 2);
        stim = 8'b0000_0001; wait_cyc(12);
        check(5'b10100, 6);

        // R10 aux in inrush keeps switch off
        stim = 8'b1000_0001; wait_cyc(8);
        check(5'b10000, 10);
        stim = 8'b0000_0001; wait_cyc(8);
        check(5'b10100, 10);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run incomplete, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule